// File: doc/BRIEF.md
# Deferred-Write SRAM Buffer with Read Forwarding

This block sits in front of a pipelined on-chip SRAM and turns every write into a deferred one. A write command carries only the address. The data follows in the next cycle as one beat (single rate) or two beats (double rate). The address and data wait in a pending buffer. They reach the array only when the next write command arrives, and that may be after any number of reads. The two beats of a pending entry sit at a word address and at its burst partner, the address with bit 0 inverted. One commit writes both beats in a single cycle, into an even bank and an odd bank.

Every read address is compared at full word width with the addresses the pending entry will write. On a match the buffered beat is returned. Otherwise the array is read. Both paths have the same two-cycle read latency, so the block behaves to its user as a plain memory in which a write is visible as soon as its data cycle has taken place.

Top module: `lw_sram`

## Requirements
- R1: After reset `rd_valid` and `rd_data` are 0 and the pending buffer holds no valid beat, so nothing can be forwarded before the first write.
- R2: A write command (`cmd_valid`=1, `cmd_write`=1) samples `cmd_addr` and `cmd_ddr`. In the next cycle `wr_lo` is taken as the beat for that address. When `cmd_ddr`=1, `wr_hi` is also taken, as the beat for the partner address (bit 0 inverted).
- R3: Written data stays in the pending buffer until the next write command. A read of a pending beat returns the buffered value, even when the array still holds an older value at that address.
- R4: When a write command arrives, the previous pending entry is committed to the array in that cycle, both beats at once, however many reads came in between. No write is lost or reordered.
- R5: Forwarding compares the full word address. A read whose address differs from a pending beat address in any bit, the high bits included, is served from the array.
- R6: A single-rate write updates only its own address. The partner word keeps its earlier value, both while the entry is pending and after it is committed.
- R7: A read command (`cmd_valid`=1, `cmd_write`=0) produces `rd_valid`=1 together with its data exactly two rising edges after the edge that sampled it. `rd_valid` is 0 in every other cycle.
- R8: `rd_data` changes only when `rd_valid` is 1. Between reads, and across repeated reads of the same address, it holds its value.
- R9: A read issued in the data cycle of a write, to that write's address, returns the data being captured in that same cycle.
- R10: A write command issued in the data cycle of the previous write commits that previous write together with its just-arriving data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write address cycle, 0 = read |
| cmd_ddr | input | 1 | Write carries two beats (double rate) |
| cmd_addr | input | AW | Word address |
| wr_lo | input | DW | Beat for the write address, taken in the data cycle |
| wr_hi | input | DW | Beat for the partner address, taken in a double-rate data cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Registered read data |

## Verification
A stale or missing pending entry shows up as an old value on `rd_data`, two edges after a read of the written address or of its partner. A commit that is lost or misdirected shows up in the same way, but only once a later write has pushed the entry out and the address is read again from the array. A wrong forwarding decision from a partial address compare returns buffered data for an address that was never written. A fault in the read pipeline changes the timing of `rd_valid` at once, or disturbs `rd_data` in a cycle with no read.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic {RATE_SDR = 1'b0, RATE_DDR = 1'b1} rate_e;
endpackage

// File: rtl/lwb_bank.sv
module lwb_bank #(
  parameter int RW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << RW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lwb_pend.sv
module lwb_pend
  import lwb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          cmd_ddr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wd_lo,
  input  logic [DW-1:0] wd_hi,
  output logic [AW-1:0] nx_addr,
  output logic [1:0]    nx_v,
  output logic [DW-1:0] nx_lo,
  output logic [DW-1:0] nx_hi,
  output logic          in_data,
  output logic [1:0]    pv_q,
  output logic [1:0]    cmt_we,
  output logic [AW-2:0] cmt_row,
  output logic [DW-1:0] cmt_d0,
  output logic [DW-1:0] cmt_d1
);
  logic [AW-1:0] pa_q;
  logic [DW-1:0] plo_q, phi_q;
  logic          dph_q;
  rate_e         rate_q;

  // effective entry: includes the beats arriving in the data cycle
  always_comb begin
    nx_addr = pa_q;
    if (dph_q) begin
      nx_v  = {rate_q == RATE_DDR, 1'b1};
      nx_lo = wd_lo;
      nx_hi = wd_hi;
    end else begin
      nx_v  = pv_q;
      nx_lo = plo_q;
      nx_hi = phi_q;
    end
  end

  // commit steering: beat 0 goes to the bank picked by address bit 0
  always_comb begin
    cmt_row = pa_q[AW-1:1];
    if (pa_q[0]) begin
      cmt_d0 = nx_hi;
      cmt_d1 = nx_lo;
      cmt_we = {nx_v[0], nx_v[1]} & {2{wr_cmd}};
    end else begin
      cmt_d0 = nx_lo;
      cmt_d1 = nx_hi;
      cmt_we = nx_v & {2{wr_cmd}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q   <= '0;
      pv_q   <= 2'b00;
      plo_q  <= '0;
      phi_q  <= '0;
      dph_q  <= 1'b0;
      rate_q <= RATE_SDR;
    end else if (wr_cmd) begin
      pa_q   <= cmd_addr;
      pv_q   <= 2'b00;
      dph_q  <= 1'b1;
      rate_q <= rate_e'(cmd_ddr);
    end else if (dph_q) begin
      pv_q  <= nx_v;
      plo_q <= nx_lo;
      phi_q <= nx_hi;
      dph_q <= 1'b0;
    end
  end

  assign in_data = dph_q;
endmodule

// File: rtl/lwb_cmp.sv
module lwb_cmp #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] nx_addr,
  input  logic [1:0]    nx_v,
  input  logic [DW-1:0] nx_lo,
  input  logic [DW-1:0] nx_hi,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic [AW-1:0] partner;
  logic hit0, hit1;

  assign partner  = {nx_addr[AW-1:1], ~nx_addr[0]};
  assign hit0     = nx_v[0] && (rd_addr == nx_addr);
  assign hit1     = nx_v[1] && (rd_addr == partner);
  assign hit      = hit0 | hit1;
  assign hit_data = hit1 ? nx_hi : nx_lo;
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_ddr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wr_lo,
  input  logic [DW-1:0] wr_hi,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int RW = AW - 1;
  localparam int NB = 2;

  logic          wr_cmd, rd_cmd;
  logic [AW-1:0] nx_addr;
  logic [1:0]    nx_v, pv_q, cmt_we;
  logic [DW-1:0] nx_lo, nx_hi, cmt_d0, cmt_d1;
  logic [RW-1:0] cmt_row;
  logic          in_data;
  logic          hit;
  logic [DW-1:0] hit_data;
  logic [DW-1:0] bk_wd [NB];
  logic [DW-1:0] bk_rd [NB];

  logic          s1_v, s1_bank, s1_hit;
  logic [DW-1:0] s1_hd;

  assign wr_cmd   = cmd_valid && cmd_write;
  assign rd_cmd   = cmd_valid && !cmd_write;
  assign bk_wd[0] = cmt_d0;
  assign bk_wd[1] = cmt_d1;

  lwb_pend #(.AW(AW), .DW(DW)) u_pend (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .cmd_ddr(cmd_ddr),
    .cmd_addr(cmd_addr), .wd_lo(wr_lo), .wd_hi(wr_hi),
    .nx_addr(nx_addr), .nx_v(nx_v), .nx_lo(nx_lo), .nx_hi(nx_hi),
    .in_data(in_data), .pv_q(pv_q), .cmt_we(cmt_we), .cmt_row(cmt_row),
    .cmt_d0(cmt_d0), .cmt_d1(cmt_d1)
  );

  lwb_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .rd_addr(cmd_addr), .nx_addr(nx_addr), .nx_v(nx_v),
    .nx_lo(nx_lo), .nx_hi(nx_hi), .hit(hit), .hit_data(hit_data)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    lwb_bank #(.RW(RW), .DW(DW)) u_bank (
      .clk(clk), .we(cmt_we[b]), .waddr(cmt_row), .wdata(bk_wd[b]),
      .re(rd_cmd), .raddr(cmd_addr[AW-1:1]), .rdata(bk_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_bank  <= 1'b0;
      s1_hit   <= 1'b0;
      s1_hd    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      s1_v <= rd_cmd;
      if (rd_cmd) begin
        s1_bank <= cmd_addr[0];
        s1_hit  <= hit;
        s1_hd   <= hit_data;
      end
      rd_valid <= s1_v;
      if (s1_v) rd_data <= s1_hit ? s1_hd : bk_rd[s1_bank];
    end
  end
endmodule

// File: rtl/lwb_chk.sv
module lwb_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    cmt_we,
  input logic [1:0]    pv_q,
  input logic          in_data
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    (cyc <= 2'd1) |-> (pv_q == 2'b00));

  a_r2_data_follows_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write) |=> in_data);

  a_r4_commit_on_write: assert property (@(posedge clk) disable iff (rst)
    (cmt_we != 2'b00) |-> (cmd_valid && cmd_write));

  a_r7_read_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (rd_valid == $past(cmd_valid && !cmd_write, 2)));

  a_r8_hold_between_reads: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 2'd1) && !rd_valid) |-> $stable(rd_data));
endmodule

bind lw_sram lwb_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .rd_valid(rd_valid), .rd_data(rd_data), .cmt_we(cmt_we),
  .pv_q(pv_q), .in_data(in_data)
);

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0, cmd_ddr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_lo = '0, wr_hi = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [N];
  logic          wp_b = 1'b0, wddr_b = 1'b0;
  logic [AW-1:0] wa_b = '0;
  logic          p1_v = 1'b0, p2_v = 1'b0;
  logic [DW-1:0] p1_d = '0, p2_d = '0, last = '0;
  string         p1_t = "", p2_t = "";

  always #4 clk = ~clk;

  lw_sram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_ddr(cmd_ddr), .cmd_addr(cmd_addr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock cycle; checks the output of the read issued two cycles earlier
  task automatic step(input logic cv, cw, ddr, input logic [AW-1:0] a,
                      input logic [DW-1:0] lo, hi, input string tag);
    logic          v0;
    logic [DW-1:0] d0;
    @(negedge clk);
    if (p2_v) begin
      chk(rd_valid === 1'b1, {p2_t, " R7 valid"}, {{(DW-1){1'b0}}, rd_valid}, 1);
      chk(rd_data === p2_d, p2_t, rd_data, p2_d);
      last = rd_data;
    end else begin
      chk(rd_valid === 1'b0, "R7 idle valid", {{(DW-1){1'b0}}, rd_valid}, 0);
      chk(rd_data === last, "R8 hold", rd_data, last);
    end
    cmd_valid = cv; cmd_write = cw; cmd_ddr = ddr; cmd_addr = a;
    wr_lo = lo; wr_hi = hi;
    if (wp_b) begin
      model[wa_b] = lo;
      if (wddr_b) model[wa_b ^ 1] = hi;
    end
    wp_b = cv && cw; wa_b = a; wddr_b = ddr;
    v0 = cv && !cw;
    d0 = model[a];
    @(posedge clk);
    p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
    p1_v = v0;   p1_d = d0;   p1_t = tag;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic ddr,
                    input logic [DW-1:0] lo, hi);
    step(1, 1, ddr, a, '0, '0, "R2");
    step(0, 0, 0, '0, lo, hi, "R2");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, 0, a, '0, '0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, '0, "idle");
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1 rd_valid", {{(DW-1){1'b0}}, rd_valid}, 0);
    chk(rd_data === '0, "R1 rd_data", rd_data, '0);

    // fill every pair with double-rate writes, then read every word (R2, R4)
    for (int a = 0; a < N; a += 2)
      wr(a[AW-1:0], 1, DW'(a * 37 + 5), DW'((a + 1) * 37 + 5));
    for (int a = 0; a < N; a++) rd(a[AW-1:0], "R4 sweep");
    wr(6'd0, 1, 16'h0a0a, 16'h0b0b);
    for (int a = 0; a < N; a++) rd(a[AW-1:0], "R4 after commit");

    // R3 / R5: pending entry at odd address 13, partner 12
    wr(6'd13, 1, 16'h1313, 16'h1212);
    rd(6'd13, "R3 pending beat0");
    rd(6'd12, "R3 pending beat1");
    rd(6'd45, "R5 high bit differs");
    rd(6'd44, "R5 partner high bit");
    rd(6'd13, "R8 repeat");
    rd(6'd13, "R8 repeat");
    idle(3);
    rd(6'd13, "R8 repeat after gap");
    wr(6'd30, 1, 16'h3030, 16'h3131);
    rd(6'd13, "R4 committed beat0");
    rd(6'd12, "R4 committed beat1");

    // R6: single-rate write leaves the partner alone
    wr(6'd20, 0, 16'h2020, 16'hdead);
    rd(6'd21, "R6 partner while pending");
    rd(6'd20, "R6 own word");
    wr(6'd40, 0, 16'h4040, 16'hbeef);
    rd(6'd21, "R6 partner after commit");
    rd(6'd20, "R6 own word committed");
    rd(6'd41, "R6 partner of pending");

    // R9: read in the data cycle
    step(1, 1, 1, 6'd50, '0, '0, "R2");
    step(1, 0, 0, 6'd50, 16'h5050, 16'h5151, "R9 beat0 in data cycle");
    rd(6'd51, "R9 beat1 next");

    // R10: write command in the data cycle of the previous write
    step(1, 1, 1, 6'd8, '0, '0, "R2");
    step(1, 1, 0, 6'd62, 16'h0808, 16'h0909, "R10");
    step(0, 0, 0, '0, 16'h6262, 16'hffff, "R10");
    rd(6'd8, "R10 committed beat0");
    rd(6'd9, "R10 committed beat1");
    rd(6'd62, "R10 new pending");
    rd(6'd63, "R10 untouched partner");

    // mixed sweep: single and double writes interleaved with reads
    for (int k = 0; k < 48; k++) begin
      logic [AW-1:0] a;
      a = AW'(k * 23 + 7);
      wr(a, k[0], DW'(k * 211 + 3), DW'(k * 97 + 11));
      rd(a, "R3 mixed");
      rd(a ^ 6'd1, "R5 mixed partner");
      rd(AW'(a + 6'd2), "R4 mixed other");
    end
    wr(6'd0, 0, 16'h7777, 16'h0);
    for (int a = 0; a < N; a++) rd(a[AW-1:0], "R4 final sweep");
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule